// File: doc/BRIEF.md
# Partial-array self-refresh address sequencer

This block sits inside a mobile DDR memory model. It holds the low-power extended mode register and runs the self-refresh address walk. A mode-register-set command with bank-address value `10` (BA1=1, BA0=0) loads the register from the address bus. The register has three fields:

- a partial-array refresh selector,
- a drive-strength code, which is brought out on a port,
- a temperature field, which is ignored.

The block checks every write. A write is rejected and flagged if any of these hold:

- the must-be-zero address bits are not zero;
- a field carries a reserved code;
- any bank is open;
- the post-write settling wait is still running.

While self refresh is active, a counter steps one row per refresh tick. The row is the low part of the counter and the bank number is the high part. The counter wraps after the last row of bank 3. A refresh strobe, carrying the bank and row, is issued only for rows inside the region that the selector keeps. All other rows are stepped over silently.

The block has two state machines. The configuration machine has states `CFG_READY` and `CFG_SETTLE`. Its transitions are:

- `CFG_READY`→`CFG_SETTLE` on an accepted write;
- `CFG_SETTLE`→`CFG_READY` when the wait count expires.

The walker has states `WLK_IDLE` and `WLK_RUN`. Its transitions are:

- `WLK_IDLE`→`WLK_RUN` when self refresh goes high, which clears the counter;
- `WLK_RUN`→`WLK_IDLE` when self refresh goes low.

Top module: `pasr_refresh_seq`

## Requirements
- R1: Reset state: selector `000` (whole array), drive code `00` (full), `cfg_busy`, `prog_err` and `ref_strobe` all low.
- R2: The register is written only when `cmd_mrs` is high with `cmd_ba` = `2'b10`. Any other `cmd_ba` value changes nothing and raises no error.
- R3: Field positions: `cmd_addr[2:0]` is the selector and `cmd_addr[6:5]` is the drive code (`00` full, `01` half, `10` quarter). `cmd_addr[4:3]` is ignored, whatever its value.
- R4: A write with any of `cmd_addr[12:7]` nonzero is rejected. The register is unchanged, and `prog_err` is high for the one cycle after the command.
- R5: A write with drive code `11`, or with selector `011`, `100` or `111`, is rejected with a one-cycle `prog_err`. `drive_code` never shows `11`.
- R6: A write while any bit of `bank_open` is high is rejected with a one-cycle `prog_err`, and the register is unchanged.
- R7: After an accepted write, `cfg_busy` is high for exactly `WAIT_CYCLES` cycles, starting the cycle after the command. A write command during that window is dropped and raises `prog_err`.
- R8: Walk order: on the rising edge of `self_ref` the counter clears to bank 0, row 0. Each cycle with `ref_tick` high in self refresh visits the next address, row first, then bank. After the last row of bank 3 it wraps to bank 0, row 0. Cycles without a tick do not advance the counter.
- R9: Kept region per selector:
  - `000`: all banks.
  - `001`: banks with the top bank bit 0.
  - `010`: bank 0 only.
  - `101`: bank 0 with the top row bit 0.
  - `110`: bank 0 with the two top row bits 0.
- R10: A tick on a row outside the kept region advances the counter with `ref_strobe` low. A kept row gives a one-cycle `ref_strobe` in the cycle after its tick, with `ref_bank` and `ref_row` set to that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power loss |
| cmd_mrs | input | 1 | Mode-register-set command strobe |
| cmd_ba | input | 2 | Bank-address bits of the command |
| cmd_addr | input | 13 | Address bits of the command |
| bank_open | input | 4 | One bit per bank, high while that bank is active |
| self_ref | input | 1 | Self refresh active |
| ref_tick | input | 1 | Refresh interval tick |
| cfg_busy | output | 1 | Post-write settling wait in progress |
| ref_strobe | output | 1 | Refresh issued for `ref_bank`/`ref_row` |
| ref_bank | output | 2 | Bank of the last issued refresh |
| ref_row | output | ROW_BITS | Row of the last issued refresh |
| drive_code | output | 2 | Stored drive-strength code |
| prog_err | output | 1 | One-cycle flag for an illegal write |

## Verification
The hardest state to reach from the ports is the end of a walk: the wrap after the last row of bank 3, and the edges of the small regions. At default size these are tens of thousands of ticks away. The bench therefore builds the block with a six-bit row. A full walk is then 256 ticks, so complete walks can be run under every selector. Each strobe is compared against its index in the walk. The wrap is reached by ticking one step past the end. A command during the settling wait is placed by issuing it on the negedge right after `cfg_busy` rises.

// File: rtl/pasr_pkg.sv
package pasr_pkg;

    typedef enum logic [2:0] {
        SEL_FULL      = 3'b000,
        SEL_HALF      = 3'b001,
        SEL_QUARTER   = 3'b010,
        SEL_EIGHTH    = 3'b101,
        SEL_SIXTEENTH = 3'b110
    } pasr_sel_e;

    typedef enum logic [1:0] {
        DRV_FULL    = 2'b00,
        DRV_HALF    = 2'b01,
        DRV_QUARTER = 2'b10
    } drv_code_e;

    typedef enum logic {
        CFG_READY,
        CFG_SETTLE
    } cfg_state_e;

    typedef enum logic {
        WLK_IDLE,
        WLK_RUN
    } wlk_state_e;

    localparam logic [1:0] EMR_BANK_SEL = 2'b10;

    function automatic logic sel_legal(input logic [2:0] code);
        return (code == 3'b000) || (code == 3'b001) || (code == 3'b010) ||
               (code == 3'b101) || (code == 3'b110);
    endfunction

    function automatic logic drv_legal(input logic [1:0] code);
        return code != 2'b11;
    endfunction

endpackage

// File: rtl/pasr_mode_reg.sv
module pasr_mode_reg
    import pasr_pkg::*;
#(
    parameter int WAIT_CYCLES = 4,
    parameter int ADDR_W      = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrs_valid,
    input  logic [1:0]        mrs_ba,
    input  logic [ADDR_W-1:0] mrs_addr,
    input  logic [3:0]        bank_active,
    output pasr_sel_e         sel,
    output drv_code_e         drv,
    output logic              busy,
    output logic              prog_err
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

    cfg_state_e       state;
    logic [CNT_W-1:0] wait_cnt;
    logic             targeted;
    logic             illegal;
    logic             accept;
    logic             reject;
    logic             ign_unused;

    // Bits [4:3] carry the temperature field, which has no effect.
    assign ign_unused = ^mrs_addr[4:3];

    always_comb begin
        targeted = mrs_valid && (mrs_ba == EMR_BANK_SEL);
        illegal  = (|bank_active) || (|mrs_addr[ADDR_W-1:7]) ||
                   !sel_legal(mrs_addr[2:0]) || !drv_legal(mrs_addr[6:5]);
        accept   = targeted && (state == CFG_READY) && !illegal;
        reject   = targeted && ((state == CFG_SETTLE) || illegal);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= CFG_READY;
            wait_cnt <= '0;
        end else begin
            unique case (state)
                CFG_READY: begin
                    if (accept) begin
                        state    <= CFG_SETTLE;
                        wait_cnt <= CNT_W'(WAIT_CYCLES - 1);
                    end
                end
                CFG_SETTLE: begin
                    if (wait_cnt == '0) state <= CFG_READY;
                    else                wait_cnt <= wait_cnt - 1'b1;
                end
                default: state <= CFG_READY;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel      <= SEL_FULL;
            drv      <= DRV_FULL;
            prog_err <= 1'b0;
        end else begin
            prog_err <= reject;
            if (accept) begin
                sel <= pasr_sel_e'(mrs_addr[2:0]);
                drv <= drv_code_e'(mrs_addr[6:5]);
            end
        end
    end

    assign busy = (state == CFG_SETTLE);

endmodule

// File: rtl/pasr_region_filter.sv
module pasr_region_filter
    import pasr_pkg::*;
#(
    parameter int ROW_BITS  = 13,
    parameter int BANK_BITS = 2
) (
    input  pasr_sel_e            sel,
    input  logic [BANK_BITS-1:0] bank,
    input  logic [ROW_BITS-1:0]  row,
    output logic                 keep
);
    logic bank0;
    logic top_row_clear;
    logic top2_row_clear;

    always_comb begin
        bank0          = (bank == '0);
        top_row_clear  = !row[ROW_BITS-1];
        top2_row_clear = (row[ROW_BITS-1 -: 2] == 2'b00);
        unique case (sel)
            SEL_FULL:      keep = 1'b1;
            SEL_HALF:      keep = !bank[BANK_BITS-1];
            SEL_QUARTER:   keep = bank0;
            SEL_EIGHTH:    keep = bank0 && top_row_clear;
            SEL_SIXTEENTH: keep = bank0 && top2_row_clear;
            default:       keep = 1'b1;
        endcase
    end

endmodule

// File: rtl/pasr_walker.sv
module pasr_walker
    import pasr_pkg::*;
#(
    parameter int ROW_BITS  = 13,
    parameter int BANK_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sr_active,
    input  logic                 tick,
    input  pasr_sel_e            sel,
    output logic                 strobe,
    output logic [BANK_BITS-1:0] bank,
    output logic [ROW_BITS-1:0]  row
);
    localparam int CNT_W = ROW_BITS + BANK_BITS;

    wlk_state_e       state;
    logic [CNT_W-1:0] addr_cnt;
    logic             keep;
    logic             step;

    pasr_region_filter #(
        .ROW_BITS (ROW_BITS),
        .BANK_BITS(BANK_BITS)
    ) u_filter (
        .sel (sel),
        .bank(addr_cnt[CNT_W-1 -: BANK_BITS]),
        .row (addr_cnt[ROW_BITS-1:0]),
        .keep(keep)
    );

    assign step = (state == WLK_RUN) && sr_active && tick;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= WLK_IDLE;
            addr_cnt <= '0;
        end else begin
            unique case (state)
                WLK_IDLE: begin
                    if (sr_active) begin
                        state    <= WLK_RUN;
                        addr_cnt <= '0;
                    end
                end
                WLK_RUN: begin
                    if (!sr_active) state    <= WLK_IDLE;
                    else if (tick)  addr_cnt <= addr_cnt + 1'b1;
                end
                default: state <= WLK_IDLE;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            bank   <= '0;
            row    <= '0;
        end else begin
            strobe <= step && keep;
            if (step && keep) begin
                bank <= addr_cnt[CNT_W-1 -: BANK_BITS];
                row  <= addr_cnt[ROW_BITS-1:0];
            end
        end
    end

endmodule

// File: rtl/pasr_refresh_seq.sv
module pasr_refresh_seq #(
    parameter int ROW_BITS    = 13,
    parameter int WAIT_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_mrs,
    input  logic [1:0]          cmd_ba,
    input  logic [12:0]         cmd_addr,
    input  logic [3:0]          bank_open,
    input  logic                self_ref,
    input  logic                ref_tick,
    output logic                cfg_busy,
    output logic                ref_strobe,
    output logic [1:0]          ref_bank,
    output logic [ROW_BITS-1:0] ref_row,
    output logic [1:0]          drive_code,
    output logic                prog_err
);
    import pasr_pkg::*;

    pasr_sel_e sel;
    drv_code_e drv;

    pasr_mode_reg #(
        .WAIT_CYCLES(WAIT_CYCLES),
        .ADDR_W     (13)
    ) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mrs_valid  (cmd_mrs),
        .mrs_ba     (cmd_ba),
        .mrs_addr   (cmd_addr),
        .bank_active(bank_open),
        .sel        (sel),
        .drv        (drv),
        .busy       (cfg_busy),
        .prog_err   (prog_err)
    );

    pasr_walker #(
        .ROW_BITS (ROW_BITS),
        .BANK_BITS(2)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sr_active(self_ref),
        .tick     (ref_tick),
        .sel      (sel),
        .strobe   (ref_strobe),
        .bank     (ref_bank),
        .row      (ref_row)
    );

    assign drive_code = drv;

endmodule

// File: rtl/pasr_seq_checker.sv
module pasr_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_mrs,
    input logic [1:0] cmd_ba,
    input logic       self_ref,
    input logic       ref_tick,
    input logic       cfg_busy,
    input logic       ref_strobe,
    input logic [1:0] drive_code,
    input logic       prog_err
);
    AST_ERR_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |-> $past(cmd_mrs) && ($past(cmd_ba) == 2'b10)); // R4
    AST_DRIVE_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        drive_code != 2'b11); // R5
    AST_REJECT_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |-> $stable(drive_code)); // R6
    AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_busy) |-> $past(cmd_mrs) && ($past(cmd_ba) == 2'b10)); // R7
    AST_DRIVE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_code) |-> $rose(cfg_busy)); // R2
    AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |-> $past(ref_tick) && $past(self_ref)); // R8
endmodule

bind pasr_refresh_seq pasr_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_mrs   (cmd_mrs),
    .cmd_ba    (cmd_ba),
    .self_ref  (self_ref),
    .ref_tick  (ref_tick),
    .cfg_busy  (cfg_busy),
    .ref_strobe(ref_strobe),
    .drive_code(drive_code),
    .prog_err  (prog_err)
);

// File: tb/sim_pasr_refresh_seq.sv
`timescale 1ns/1ps
module sim_pasr_refresh_seq;
    localparam int RB    = 6;
    localparam int NROWS = 1 << RB;
    localparam int NADDR = 4 * NROWS;
    localparam int WAITC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_mrs = 1'b0;
    logic [1:0]    cmd_ba = 2'b00;
    logic [12:0]   cmd_addr = '0;
    logic [3:0]    bank_open = '0;
    logic          self_ref = 1'b0;
    logic          ref_tick = 1'b0;
    logic          cfg_busy;
    logic          ref_strobe;
    logic [1:0]    ref_bank;
    logic [RB-1:0] ref_row;
    logic [1:0]    drive_code;
    logic          prog_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pasr_refresh_seq #(.ROW_BITS(RB), .WAIT_CYCLES(WAITC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_mrs(cmd_mrs), .cmd_ba(cmd_ba),
        .cmd_addr(cmd_addr), .bank_open(bank_open), .self_ref(self_ref),
        .ref_tick(ref_tick), .cfg_busy(cfg_busy), .ref_strobe(ref_strobe),
        .ref_bank(ref_bank), .ref_row(ref_row), .drive_code(drive_code),
        .prog_err(prog_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit kept(input int sel, input int idx);
        int b = idx / NROWS;
        int r = idx % NROWS;
        case (sel)
            0: return 1'b1;
            1: return b < 2;
            2: return b == 0;
            5: return (b == 0) && (r < NROWS / 2);
            6: return (b == 0) && (r < NROWS / 4);
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [12:0] mk_addr(input int sel, input int drv, input int tmp, input int high);
        logic [12:0] a;
        a = '0;
        a[2:0]  = 3'(sel);
        a[4:3]  = 2'(tmp);
        a[6:5]  = 2'(drv);
        a[12:7] = 6'(high);
        return a;
    endfunction

    // Issue one command; returns on the negedge after the capturing edge.
    task automatic do_mrs(input logic [1:0] ba, input logic [12:0] a, input logic [3:0] act);
        @(negedge clk);
        cmd_mrs = 1'b1; cmd_ba = ba; cmd_addr = a; bank_open = act;
        @(negedge clk);
        cmd_mrs = 1'b0; cmd_ba = 2'b00; cmd_addr = '0; bank_open = '0;
    endtask

    task automatic wait_ready();
        while (cfg_busy) @(negedge clk);
    endtask

    // Full walk under the current selector; checks every visited index.
    task automatic walk_check(input int sel, input int exp_cnt, input string req);
        int cnt = 0;
        int bad = 0;
        wait_ready();
        @(negedge clk); self_ref = 1'b1;
        @(negedge clk); ref_tick = 1'b1;
        for (int i = 0; i < NADDR; i++) begin
            @(negedge clk);
            if (ref_strobe !== kept(sel, i)) bad++;
            if (ref_strobe) begin
                cnt++;
                if (int'(ref_bank) * NROWS + int'(ref_row) != i) bad++;
            end
        end
        ref_tick = 1'b0; self_ref = 1'b0;
        @(negedge clk);
        chk(cnt == exp_cnt, req, cnt, exp_cnt);
        chk(bad == 0, "R10 strobe/address per row", bad, 0);
    endtask

    task automatic t_reset();
        chk(drive_code == 2'b00, "R1 drive after reset", drive_code, 0);
        chk(cfg_busy == 1'b0, "R1 busy after reset", cfg_busy, 0);
        chk(prog_err == 1'b0, "R1 err after reset", prog_err, 0);
        chk(ref_strobe == 1'b0, "R1 strobe after reset", ref_strobe, 0);
        walk_check(0, NADDR, "R1 R9 full coverage after reset");
    endtask

    task automatic t_fields();
        do_mrs(2'b10, mk_addr(1, 1, 3, 0), 4'b0000);
        chk(prog_err == 1'b0, "R3 legal write no err", prog_err, 0);
        chk(drive_code == 2'b01, "R3 drive field", drive_code, 1);
        walk_check(1, NADDR / 2, "R3 R9 selector 001 coverage");
    endtask

    task automatic t_bank_sel();
        do_mrs(2'b01, mk_addr(0, 2, 0, 0), 4'b0000);
        chk(prog_err == 1'b0 && cfg_busy == 1'b0, "R2 ba=01 no err/busy", {prog_err, cfg_busy}, 0);
        chk(drive_code == 2'b01, "R2 ba=01 ignored", drive_code, 1);
        do_mrs(2'b11, mk_addr(0, 2, 0, 0), 4'b0000);
        chk(drive_code == 2'b01, "R2 ba=11 ignored", drive_code, 1);
        do_mrs(2'b00, mk_addr(2, 0, 0, 0), 4'b0000);
        chk(prog_err == 1'b0, "R2 ba=00 no err", prog_err, 0);
        walk_check(1, NADDR / 2, "R2 selector unchanged");
    endtask

    task automatic t_high_bits();
        do_mrs(2'b10, mk_addr(2, 2, 0, 6'h04), 4'b0000);
        chk(prog_err == 1'b1, "R4 high bit err", prog_err, 1);
        chk(drive_code == 2'b01, "R4 drive unchanged", drive_code, 1);
        chk(cfg_busy == 1'b0, "R4 no busy", cfg_busy, 0);
        @(negedge clk);
        chk(prog_err == 1'b0, "R4 err one cycle", prog_err, 0);
        do_mrs(2'b10, mk_addr(2, 2, 0, 6'h20), 4'b0000);
        chk(prog_err == 1'b1, "R4 bit 12 err", prog_err, 1);
    endtask

    task automatic t_reserved();
        do_mrs(2'b10, mk_addr(0, 3, 0, 0), 4'b0000);
        chk(prog_err == 1'b1, "R5 drive 11 err", prog_err, 1);
        chk(drive_code == 2'b01, "R5 drive 11 rejected", drive_code, 1);
        for (int s = 3; s <= 7; s++) begin
            if (s == 5 || s == 6) continue;
            do_mrs(2'b10, mk_addr(s, 2, 0, 0), 4'b0000);
            chk(prog_err == 1'b1, $sformatf("R5 selector %0d err", s), prog_err, 1);
        end
        chk(drive_code == 2'b01, "R5 drive kept", drive_code, 1);
        walk_check(1, NADDR / 2, "R5 selector kept");
    endtask

    task automatic t_bank_active();
        do_mrs(2'b10, mk_addr(2, 2, 0, 0), 4'b0100);
        chk(prog_err == 1'b1, "R6 open bank err", prog_err, 1);
        chk(drive_code == 2'b01, "R6 drive unchanged", drive_code, 1);
        chk(cfg_busy == 1'b0, "R6 no busy", cfg_busy, 0);
    endtask

    task automatic t_busy();
        int n = 0;
        do_mrs(2'b10, mk_addr(2, 2, 0, 0), 4'b0000);
        chk(drive_code == 2'b10, "R7 write accepted", drive_code, 2);
        while (cfg_busy && n < 50) begin n++; @(negedge clk); end
        chk(n == WAITC, "R7 busy length", n, WAITC);
        do_mrs(2'b10, mk_addr(0, 1, 0, 0), 4'b0000);
        chk(cfg_busy == 1'b1, "R7 busy again", cfg_busy, 1);
        cmd_mrs = 1'b1; cmd_ba = 2'b10; cmd_addr = mk_addr(0, 0, 0, 0);
        @(negedge clk);
        cmd_mrs = 1'b0; cmd_ba = 2'b00; cmd_addr = '0;
        chk(prog_err == 1'b1, "R7 write during busy err", prog_err, 1);
        chk(drive_code == 2'b01, "R7 write during busy dropped", drive_code, 1);
        walk_check(0, NADDR, "R7 R9 dropped write kept selector 000");
        do_mrs(2'b10, mk_addr(2, 2, 0, 0), 4'b0000);
        walk_check(2, NROWS, "R9 selector 010 coverage");
    endtask

    task automatic t_small_regions();
        do_mrs(2'b10, mk_addr(5, 0, 0, 0), 4'b0000);
        walk_check(5, NROWS / 2, "R9 selector 101 coverage");
        do_mrs(2'b10, mk_addr(6, 0, 0, 0), 4'b0000);
        walk_check(6, NROWS / 4, "R9 R10 selector 110 coverage");
    endtask

    task automatic t_order();
        do_mrs(2'b10, mk_addr(0, 0, 0, 0), 4'b0000);
        wait_ready();
        @(negedge clk); self_ref = 1'b1;
        @(negedge clk); ref_tick = 1'b1;
        for (int i = 0; i < 3; i++) @(negedge clk);
        ref_tick = 1'b0;
        @(negedge clk);
        chk(ref_strobe == 1'b0, "R8 no tick no strobe", ref_strobe, 0);
        @(negedge clk);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
        chk(ref_strobe && ref_row == RB'(3) && ref_bank == 2'd0, "R8 counter held without tick",
            int'(ref_row), 3);
        self_ref = 1'b0;
        @(negedge clk);
        self_ref = 1'b1;
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk);
        chk(ref_strobe && ref_row == '0 && ref_bank == 2'd0, "R8 restart at zero",
            int'(ref_row), 0);
        for (int i = 1; i < NADDR; i++) @(negedge clk);
        chk(ref_bank == 2'd3 && ref_row == RB'(NROWS - 1), "R8 last address",
            int'(ref_bank) * NROWS + int'(ref_row), NADDR - 1);
        @(negedge clk);
        chk(ref_strobe && ref_bank == 2'd0 && ref_row == '0, "R8 wrap to zero",
            int'(ref_bank) * NROWS + int'(ref_row), 0);
        ref_tick = 1'b0; self_ref = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_bank_sel();
        t_high_bits();
        t_reserved();
        t_bank_active();
        t_busy();
        t_small_regions();
        t_order();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule